// File: doc/BRIEF.md
# Staircase Gate Pattern Rotator

This block drives the insertion gates of the submodules in one arm of a modular multilevel converter that runs fundamental-frequency staircase modulation. A phase counter advances once per sample clock inside each fundamental period. Every base pattern has its own switching-angle threshold. A base pattern inserts its submodule from its threshold until half a period later, so on and off times are equal over one period.

The patterns are not tied to fixed submodules. At every fundamental-period tick the assignment moves on by one submodule. Over four periods each of the four submodules therefore carries each base pattern once, and the charge and discharge intervals even out between the capacitors. The lower arm receives the bitwise complement of the upper-arm gates.

The period length and the thresholds come from an external table indexed by modulation index. The block captures them only at the period tick, so a change of index never cuts a step short.

Top module: `stair_rotate_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first period tick, every upper-arm gate is 0 (bypassed). A gate value of 1 means inserted.
- R2: Each lower-arm gate is always the bitwise complement of the upper-arm gate of the same index.
- R3: In the period that starts with the first tick after reset, submodule i follows base pattern i. Base pattern j takes its threshold from bits [j*PHASE_W +: PHASE_W] of `angleIn`.
- R4: Each later tick advances the assignment by one, so in the k-th period after reset (counting from 0) submodule i follows base pattern (i + k) mod 4. The sequence repeats every four periods.
- R5: The clock edge that samples a tick sets the phase to 0. After that the phase rises by one per clock. Each gate is registered: the gate value visible after an edge reflects the phase held before that edge. Pattern j is inserted when threshold_j <= phase < threshold_j + floor(P/2), where P is the captured period.
- R6: If no tick arrives, the phase stops at P-1 and the gates hold their value until the next tick. The assignment does not move without a tick.
- R7: The period and threshold inputs are captured only on the edge that samples a tick. Changes to them between ticks do not affect the current period.
- R8: With an even P, a tick every P clocks and thresholds below P/2, every submodule is inserted for exactly P/2 clocks per period.
- R9: A threshold of 0 inserts from phase 0. A threshold of P or more never inserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleTick | input | 1 | One-clock pulse marking the start of a fundamental period |
| periodIn | input | PHASE_W | Clocks per fundamental period, captured at the tick |
| angleIn | input | NUM_SM*PHASE_W | Switching-angle thresholds, one field per base pattern, captured at the tick |
| gateUpper | output | NUM_SM | Upper-arm insertion gates, one per submodule |
| gateLower | output | NUM_SM | Lower-arm insertion gates, complement of gateUpper |

## Verification
The bench builds the block with NUM_SM = 4 and PHASE_W = 12. It uses periods of a few dozen clocks, so a full four-period rotation, a stalled phase counter and several changes of modulation index all fit in a few thousand clocks. Directed periods place thresholds at 0, at half a period and at or beyond the period, and they change the inputs in the middle of a period. Random periods with ticks that arrive early or late cover the cases where the saturation and capture rules interact.

// File: rtl/stair_pkg.sv
package stair_pkg;

  // Strobes from the rotation control to the gate datapath.
  typedef struct packed {
    logic load;     // tick seen this clock: capture inputs, restart phase
    logic advance;  // assignment moves on by one submodule
    logic running;  // at least one tick since reset
  } ctrlStrobe_t;

endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import stair_pkg::*;
#(
  parameter int NUM_SM = 4,
  parameter int PTR_W  = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cycleTick,
  output ctrlStrobe_t      strobe,
  output logic [PTR_W-1:0] rotPtr
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_SM - 1);

  logic running;

  always_comb begin
    strobe.load    = cycleTick;
    strobe.advance = cycleTick & running;
    strobe.running = running;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      rotPtr  <= '0;
    end else if (cycleTick) begin
      running <= 1'b1;
      if (running) begin
        rotPtr <= (rotPtr == LAST_PTR) ? '0 : rotPtr + 1'b1;
      end
    end
  end

  // R3: the first tick after reset leaves the assignment at its origin
  assert_first_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (cycleTick && !running) |=> (rotPtr == '0));

  // R6: the assignment only moves on a tick
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cycleTick |=> $stable(rotPtr));

  // R4: a later tick always changes the assignment
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (rst)
    (cycleTick && running) |=> !$stable(rotPtr));

endmodule

// File: rtl/pattern_window.sv
module pattern_window #(
  parameter int PHASE_W = 16
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [PHASE_W-1:0] angle,
  input  logic [PHASE_W-1:0] halfPeriod,
  output logic               inserted
);

  logic [PHASE_W:0] phaseExt;
  logic [PHASE_W:0] riseAt;
  logic [PHASE_W:0] fallAt;

  always_comb begin
    phaseExt = {1'b0, phase};
    riseAt   = {1'b0, angle};
    fallAt   = riseAt + {1'b0, halfPeriod};
    inserted = (phaseExt >= riseAt) && (phaseExt < fallAt);
  end

endmodule

// File: rtl/stair_datapath.sv
module stair_datapath
  import stair_pkg::*;
#(
  parameter int NUM_SM  = 4,
  parameter int PHASE_W = 16,
  parameter int PTR_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobe_t                 strobe,
  input  logic [PTR_W-1:0]            rotPtr,
  input  logic [PHASE_W-1:0]          periodIn,
  input  logic [NUM_SM*PHASE_W-1:0]   angleIn,
  output logic [NUM_SM-1:0]           gateUpper
);

  localparam logic [PTR_W:0] SM_COUNT = (PTR_W+1)'(NUM_SM);

  logic [PHASE_W-1:0] periodReg;
  logic [PHASE_W-1:0] angleReg [NUM_SM];
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] halfPeriod;
  logic [PHASE_W-1:0] lastPhase;
  logic [NUM_SM-1:0]  patOn;
  logic [NUM_SM-1:0]  gateNext;

  assign halfPeriod = {1'b0, periodReg[PHASE_W-1:1]};
  assign lastPhase  = periodReg - 1'b1;

  // One window comparator per base pattern
  for (genvar j = 0; j < NUM_SM; j++) begin : g_pat
    pattern_window #(.PHASE_W(PHASE_W)) u_win (
      .phase     (phase),
      .angle     (angleReg[j]),
      .halfPeriod(halfPeriod),
      .inserted  (patOn[j])
    );
  end

  // Submodule i follows base pattern (i + rotPtr) mod NUM_SM
  for (genvar i = 0; i < NUM_SM; i++) begin : g_sel
    localparam logic [PTR_W:0] OFFS = (PTR_W+1)'(i);
    logic [PTR_W:0]   idxSum;
    logic [PTR_W-1:0] idxSel;
    always_comb begin
      idxSum = OFFS + {1'b0, rotPtr};
      if (idxSum >= SM_COUNT) idxSum = idxSum - SM_COUNT;
      idxSel = idxSum[PTR_W-1:0];
    end
    assign gateNext[i] = strobe.running & patOn[idxSel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      periodReg <= '0;
      phase     <= '0;
      gateUpper <= '0;
      for (int j = 0; j < NUM_SM; j++) angleReg[j] <= '0;
    end else begin
      gateUpper <= gateNext;
      if (strobe.load) begin
        periodReg <= periodIn;
        phase     <= '0;
        for (int j = 0; j < NUM_SM; j++) angleReg[j] <= angleIn[j*PHASE_W +: PHASE_W];
      end else if (strobe.running && (phase != lastPhase)) begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R5: a tick restarts the phase
  assert_phase_clear_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (phase == '0));

  // R6: the phase never runs past the last count of the period
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
    (periodReg != '0) |-> (phase < periodReg));

  // R7: captured period only changes on a tick
  assert_hold_period_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(periodReg));

  // R1: no insertion before the first tick
  assert_idle_gates_R1: assert property (@(posedge clk) disable iff (rst)
    !strobe.running |=> (gateUpper == '0));

endmodule

// File: rtl/stair_rotate_gen.sv
module stair_rotate_gen
  import stair_pkg::*;
#(
  parameter int NUM_SM  = 4,
  parameter int PHASE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cycleTick,
  input  logic [PHASE_W-1:0]        periodIn,
  input  logic [NUM_SM*PHASE_W-1:0] angleIn,
  output logic [NUM_SM-1:0]         gateUpper,
  output logic [NUM_SM-1:0]         gateLower
);

  localparam int PTR_W = (NUM_SM > 1) ? $clog2(NUM_SM) : 1;

  ctrlStrobe_t      strobe;
  logic [PTR_W-1:0] rotPtr;

  rot_ctrl #(.NUM_SM(NUM_SM), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cycleTick(cycleTick),
    .strobe   (strobe),
    .rotPtr   (rotPtr)
  );

  stair_datapath #(.NUM_SM(NUM_SM), .PHASE_W(PHASE_W), .PTR_W(PTR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rotPtr   (rotPtr),
    .periodIn (periodIn),
    .angleIn  (angleIn),
    .gateUpper(gateUpper)
  );

  // R2: lower arm is the complement of the upper arm
  assign gateLower = ~gateUpper;

endmodule

// File: tb/tb_stair_rotate_gen.sv
module tb_stair_rotate_gen;

  localparam int NSM = 4;
  localparam int PW  = 12;

  logic           clk = 1'b0;
  logic           rst;
  logic           tick;
  logic [PW-1:0]  periodIn;
  logic [PW-1:0]  angIn [NSM];
  logic [NSM*PW-1:0] angleFlat;
  logic [NSM-1:0] gateUpper;
  logic [NSM-1:0] gateLower;

  assign angleFlat = {angIn[3], angIn[2], angIn[1], angIn[0]};

  stair_rotate_gen #(.NUM_SM(NSM), .PHASE_W(PW)) dut (
    .clk      (clk),
    .rst      (rst),
    .cycleTick(tick),
    .periodIn (periodIn),
    .angleIn  (angleFlat),
    .gateUpper(gateUpper),
    .gateLower(gateLower)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0;
  int    failures = 0;
  bit    chkEn = 0;
  string curReq = "R5";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  int       mPhase, mPtr, mP;
  int       mA [NSM];
  bit       mRun;
  logic [NSM-1:0] mGate;

  function automatic logic [NSM-1:0] calcGates(int ph, int ptr, bit run, int p, int a0, int a1, int a2, int a3);
    int a [NSM];
    logic [NSM-1:0] g;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    for (int i = 0; i < NSM; i++) begin
      int j;
      j = (i + ptr) % NSM;
      g[i] = run && (ph >= a[j]) && (ph < a[j] + p / 2);
    end
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase <= 0; mPtr <= 0; mRun <= 0; mP <= 0; mGate <= '0;
      for (int j = 0; j < NSM; j++) mA[j] <= 0;
    end else begin
      mGate <= calcGates(mPhase, mPtr, mRun, mP, mA[0], mA[1], mA[2], mA[3]);
      if (tick) begin
        mP <= int'(periodIn);
        for (int j = 0; j < NSM; j++) mA[j] <= int'(angIn[j]);
        mPhase <= 0;
        if (mRun) mPtr <= (mPtr + 1) % NSM;
        mRun <= 1;
      end else if (mRun && mPhase != ((mP - 1) & 32'hFFF)) begin
        mPhase <= mPhase + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chkEn) begin
      check(gateUpper == mGate, curReq, int'(gateUpper), int'(mGate));
      check(gateLower == ~gateUpper, "R2", int'(gateLower), int'(~gateUpper));
    end
  end

  task automatic plainCycle(input int len);
    tick = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  // One period of len clocks; counts insertion per submodule and the first
  // inserted phase, checked directly against the requirements.
  task automatic countedCycle(input int len, input int ptrExp, input int chgAt, input string tag);
    int cnt [NSM];
    int first [NSM];
    int expA [NSM];
    for (int i = 0; i < NSM; i++) begin
      cnt[i] = 0; first[i] = -1; expA[i] = int'(angIn[i]);
    end
    tick = 1'b1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      tick = 1'b0;
      if (k >= 1) begin
        for (int i = 0; i < NSM; i++) begin
          if (gateUpper[i]) begin
            cnt[i]++;
            if (first[i] < 0) first[i] = k - 1;
          end
        end
      end
      if (k == chgAt) begin
        periodIn = 12'd24;
        for (int j = 0; j < NSM; j++) angIn[j] = 12'd1;
      end
    end
    for (int i = 0; i < NSM; i++) begin
      check(cnt[i] == len / 2, "R8", cnt[i], len / 2);
      check(first[i] == expA[(i + ptrExp) % NSM], tag, first[i], expA[(i + ptrExp) % NSM]);
    end
  endtask

  initial begin
    logic [NSM-1:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; tick = 1'b0; periodIn = '0;
    for (int j = 0; j < NSM; j++) angIn[j] = '0;

    repeat (3) @(negedge clk);
    check(gateUpper == '0, "R1", int'(gateUpper), 0);
    check(gateLower == '1, "R1", int'(gateLower), 15);
    rst = 1'b0;
    chkEn = 1'b1;
    curReq = "R1";
    periodIn = 12'd40;
    repeat (10) @(negedge clk);
    check(gateUpper == '0, "R1", int'(gateUpper), 0);

    // Directed rotation over two full four-period rounds
    angIn[0] = 12'd3; angIn[1] = 12'd7; angIn[2] = 12'd11; angIn[3] = 12'd15;
    curReq = "R5";
    for (int c = 0; c < 8; c++) countedCycle(40, c % 4, -1, (c == 0) ? "R3" : "R4");

    // Inputs change in the middle of a period: no effect until next tick
    curReq = "R7";
    countedCycle(40, 0, 12, "R7");
    periodIn = 12'd40;
    angIn[0] = 12'd5; angIn[1] = 12'd2; angIn[2] = 12'd9; angIn[3] = 12'd0;
    plainCycle(40);

    // Late tick: phase stops at the end, gates hold
    curReq = "R6";
    tick = 1'b1;
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      tick = 1'b0;
      if (k == 60) held = gateUpper;
      if (k == 89) check(gateUpper == held, "R6", int'(gateUpper), int'(held));
    end

    // Threshold boundaries: 0, half period, period, beyond period
    curReq = "R9";
    periodIn = 12'd32;
    angIn[0] = 12'd0; angIn[1] = 12'd32; angIn[2] = 12'd16; angIn[3] = 12'd200;
    for (int c = 0; c < 4; c++) plainCycle(32);

    // Random periods, thresholds and tick spacing
    curReq = "R5";
    for (int c = 0; c < 14; c++) begin
      int p;
      p = 16 + 2 * int'($urandom % 24);
      periodIn = PW'(p);
      for (int j = 0; j < NSM; j++) angIn[j] = PW'($urandom % (p / 2 + 2));
      plainCycle(p + int'($urandom % 7) - 3);
    end

    // Reset in mid-run: rotation restarts at its origin
    curReq = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(gateUpper == '0, "R1", int'(gateUpper), 0);
    rst = 1'b0;
    curReq = "R3";
    periodIn = 12'd36;
    angIn[0] = 12'd14; angIn[1] = 12'd1; angIn[2] = 12'd8; angIn[3] = 12'd4;
    countedCycle(36, 0, -1, "R3");
    countedCycle(36, 1, -1, "R4");
    plainCycle(4);

    chkEn = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule